// File: doc/BRIEF.md
# Reconfigurable Bernstein Stochastic Evaluator

This block evaluates a programmable polynomial of degree `DEG`, written in Bernstein form, with stochastic arithmetic. A binary input `t` and `DEG+1` binary coefficients are each turned into a random bit stream whose density of ones equals the value. Each cycle the core counts the ones among the `DEG` input-stream bits. That count `k` picks the bit of coefficient stream `k` as the output bit. Over a window of `2^W` cycles, a counter adds up the output ones and presents a `W`-bit result close to `2^W · Σ b_i·C(n,i)·t^i·(1−t)^(n−i)`.

To run an evaluation, load the coefficients through the configuration port while the block is idle, then hand over a `t` value on the input stream. The result appears on the output stream. The input handshake completes when `in_valid` and `in_ready` are both high on a rising edge, and the output handshake completes when `out_valid` and `out_ready` are both high. `in_ready` is high only while the block is idle, meaning no window is running and no result is waiting. A result is held on `out_y` with `out_valid` high, for as many cycles as `out_ready` stays low. While it is held, new input and configuration writes are refused. Loading a new set of coefficients is the only way to change the function.

Top module: `bern_sc_eval`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `out_y` is 0. All coefficients reset to 0.
- R2: A value `v` is encoded as a stream that is one when (LFSR state − 1) < `v`. Code 0 therefore gives an all-zero stream, code `2^W−1` gives an all-one stream, and any other code gives a density of ones of about `v/(2^W−1)`. All `2·DEG+1` streams come from separate LFSRs, which never reach the all-zero state.
- R3: With `t` = 0 every input bit is 0, so the result equals the count of coefficient stream 0. With `b0` = 0 the result is exactly 0.
- R4: With `t` = `2^W−1` every input bit is 1, so the result equals the count of coefficient stream `DEG`. With `b_DEG` = 0 the result is exactly 0.
- R5: For the gamma coefficients (0.0955, 0.7207, 0.3476, 0.9988, 0.7017, 0.9695, 0.9939, quantized by rounding ×1023), the result lies within 64 LSB of `1024·B(t/1023)`, capped at 1023.
- R6: `out_valid` rises exactly `2^W` rising edges after the edge that accepts the input.
- R7: The result saturates at `2^W−1` when all `2^W` output bits are one.
- R8: While `out_valid` is high and `out_ready` is low, three things hold: `out_valid` stays high, `out_y` is stable, and `in_ready` is 0, so `in_valid` is ignored.
- R9: A configuration write (`cfg_we`, index `cfg_idx`, value `cfg_val`) takes effect only while `in_ready` is 1 and `cfg_idx` ≤ `DEG`. Otherwise it is ignored.
- R10: Reprogramming the coefficients changes the function. The coefficients `round(i·1023/DEG)` make the result within 48 LSB of `t`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input value offered |
| in_ready | output | 1 | Block idle, input accepted |
| in_t | input | W | Input value t, code/(2^W−1) |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes result |
| out_y | output | W | Result, ones counted over 2^W cycles, saturated |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_idx | input | $clog2(DEG+1) | Coefficient index |
| cfg_val | input | W | Coefficient code |

## Verification
The bench builds the block with its defaults: degree 6, 10-bit values and a 1024-cycle window, which is the seven-coefficient gamma configuration. The input codes 0 and 1023 make every input stream constant, and the coefficient codes 0 and 1023 make a coefficient stream constant. With these codes, window length, saturation, refused writes and back-pressure have exact expected values. The gamma and identity coefficient sets exercise the stochastic path against a floating-point evaluation with a variance tolerance.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  // Right-shifting Galois feedback masks of maximal-length LFSRs
  function automatic logic [15:0] galois_mask(input int w);
    case (w)
      8:       return 16'h00B8;
      9:       return 16'h0110;
      10:      return 16'h0240;
      11:      return 16'h0500;
      12:      return 16'h0E08;
      13:      return 16'h1C80;
      14:      return 16'h3802;
      15:      return 16'h6000;
      16:      return 16'hB400;
      default: return 16'h0240;
    endcase
  endfunction

  // Distinct non-zero start state for each stream
  function automatic int stream_seed(input int idx, input int w);
    return ((idx * 379 + 101) % ((1 << w) - 1)) + 1;
  endfunction
endpackage

// File: rtl/bsc_rand.sv
module bsc_rand #(
  parameter int W   = 10,
  parameter int IDX = 0,
  parameter bit REV = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  output logic         bit_o
);
  localparam logic [15:0]  M16  = bsc_pkg::galois_mask(W);
  localparam logic [W-1:0] MASK = M16[W-1:0];
  localparam int           SD   = bsc_pkg::stream_seed(IDX, W);
  localparam logic [W-1:0] SEED = SD[W-1:0];

  logic [W-1:0] state;
  logic [W-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEED;
    else if (state[0]) state <= (state >> 1) ^ MASK;
    else state <= state >> 1;
  end

  generate
    if (REV) begin : g_rev
      for (genvar b = 0; b < W; b++) begin : g_bit
        assign seen[b] = state[W-1-b];
      end
    end else begin : g_fwd
      assign seen = state;
    end
  endgenerate

  assign bit_o = (seen - W'(1)) < level;

  // LFSR must never lock up in the all-zero state
  assert_lfsr_live_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
endmodule

// File: rtl/bsc_core.sv
module bsc_core #(
  parameter int DEG = 6
) (
  input  logic [DEG-1:0] xbits,
  input  logic [DEG:0]   zbits,
  output logic           ybit
);
  localparam int KW = $clog2(DEG + 1);

  logic [KW-1:0] k;

  always_comb begin
    k = '0;
    for (int i = 0; i < DEG; i++) k = k + KW'(xbits[i]);
  end

  assign ybit = zbits[k];
endmodule

// File: rtl/bsc_win.sv
module bsc_win #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         ybit,
  input  logic         out_ready,
  output logic         busy,
  output logic         out_valid,
  output logic [W-1:0] out_y
);
  localparam logic [W-1:0] LAST = '1;

  logic [W-1:0] cyc;
  logic [W:0]   acc;
  logic         done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cyc  <= '0;
      acc  <= '0;
    end else begin
      if (start) begin
        busy <= 1'b1;
        cyc  <= '0;
        acc  <= '0;
      end else if (busy) begin
        acc <= acc + {{W{1'b0}}, ybit};
        cyc <= cyc + W'(1);
        if (cyc == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
      if (done && out_ready) done <= 1'b0;
    end
  end

  assign out_valid = done;
  assign out_y     = acc[W] ? LAST : acc[W-1:0];

  assert_acc_bounded_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (acc <= {1'b0, cyc}));

  assert_hold_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_y)));

  assert_done_after_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(busy));

  assert_release_on_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_valid) |-> $past(out_ready));
endmodule

// File: rtl/bern_sc_eval.sv
module bern_sc_eval #(
  parameter int DEG = 6,
  parameter int W   = 10,
  localparam int IW = $clog2(DEG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_t,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  out_y,
  input  logic          cfg_we,
  input  logic [IW-1:0] cfg_idx,
  input  logic [W-1:0]  cfg_val
);
  logic [W-1:0] coef_q [DEG+1];
  logic [W-1:0] t_q;
  logic [DEG-1:0] xbits;
  logic [DEG:0]   zbits;
  logic ybit, busy, start, wr_ok;

  assign in_ready = !busy && !out_valid;
  assign start    = in_valid && in_ready;
  assign wr_ok    = cfg_we && in_ready && (int'(cfg_idx) <= DEG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t_q <= '0;
      for (int i = 0; i <= DEG; i++) coef_q[i] <= '0;
    end else begin
      if (start) t_q <= in_t;
      if (wr_ok) coef_q[cfg_idx] <= cfg_val;
    end
  end

  generate
    for (genvar i = 0; i < DEG; i++) begin : g_x
      bsc_rand #(.W(W), .IDX(i), .REV(i % 2 == 1)) u_rx (
        .clk(clk), .rst_n(rst_n), .level(t_q), .bit_o(xbits[i]));
    end
    for (genvar j = 0; j <= DEG; j++) begin : g_z
      bsc_rand #(.W(W), .IDX(DEG + j), .REV(j % 2 == 0)) u_rz (
        .clk(clk), .rst_n(rst_n), .level(coef_q[j]), .bit_o(zbits[j]));
    end
  endgenerate

  bsc_core #(.DEG(DEG)) u_core (.xbits(xbits), .zbits(zbits), .ybit(ybit));

  bsc_win #(.W(W)) u_win (
    .clk(clk), .rst_n(rst_n), .start(start), .ybit(ybit),
    .out_ready(out_ready), .busy(busy), .out_valid(out_valid), .out_y(out_y));

  assert_no_write_when_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !in_ready) |=> $stable(coef_q[0]));

  assert_busy_after_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !in_ready);
endmodule

// File: tb/tb_bern_sc_eval.sv
`timescale 1ns/1ps
module tb_bern_sc_eval;
  localparam int DEG = 6;
  localparam int W   = 10;
  localparam int IW  = $clog2(DEG + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0, cfg_we = 1'b0;
  logic [W-1:0] in_t = '0, cfg_val = '0;
  logic [IW-1:0] cfg_idx = '0;
  logic in_ready, out_valid;
  logic [W-1:0] out_y;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  real bcoef [DEG+1];

  always #2.5 clk = ~clk;

  bern_sc_eval #(.DEG(DEG), .W(W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_t(in_t), .out_valid(out_valid), .out_ready(out_ready), .out_y(out_y),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_val(cfg_val));

  task automatic check(input string req, input int act, input int exp_v, input int tol);
    int d = act - exp_v;
    n_chk++;
    if (d < 0) d = -d;
    if (d > tol) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d tol=%0d", req, act, exp_v, tol);
    end
  endtask

  task automatic wr(input int idx, input int val);
    @(negedge clk); cfg_we = 1; cfg_idx = IW'(idx); cfg_val = W'(val);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic load(input int codes [DEG+1]);
    for (int i = 0; i <= DEG; i++) wr(i, codes[i]);
  endtask

  // start a window, wait for the result, take it
  task automatic run(input int t, output int y);
    int guard = 0;
    @(negedge clk); in_valid = 1; in_t = W'(t);
    @(negedge clk); in_valid = 0;
    while (!out_valid && guard < 5000) begin @(negedge clk); guard++; end
    y = int'(out_y);
    out_ready = 1; @(negedge clk); out_ready = 0;
  endtask

  function automatic real bern(input int codes [DEG+1], input int t);
    real p = real'(t) / 1023.0, s = 0.0;
    for (int i = 0; i <= DEG; i++) begin
      real c = 1.0, term;
      for (int j = 0; j < i; j++) c = c * real'(DEG - j) / real'(j + 1);
      term = c * real'(codes[i]) / 1023.0;
      for (int j = 0; j < i; j++) term = term * p;
      for (int j = 0; j < DEG - i; j++) term = term * (1.0 - p);
      s = s + term;
    end
    return s;
  endfunction

  function automatic int expect_y(input int codes [DEG+1], input int t);
    int e = $rtoi(bern(codes, t) * 1024.0 + 0.5);
    return (e > 1023) ? 1023 : e;
  endfunction

  task automatic t_reset;
    check("R1 in_ready", int'(in_ready), 1, 0);
    check("R1 out_valid", int'(out_valid), 0, 0);
    check("R1 out_y", int'(out_y), 0, 0);
  endtask

  task automatic t_ends;
    int c [DEG+1];
    int y;
    for (int i = 0; i <= DEG; i++) c[i] = 1023;
    c[0] = 0; load(c); run(0, y);
    check("R3 t=0 selects b0=0", y, 0, 0);
    c[0] = 1023; c[DEG] = 0; load(c); run(1023, y);
    check("R4 t=max selects bDEG=0", y, 0, 0);
    run(0, y);
    check("R7 saturation at 1023", y, 1023, 0);
    check("R2 full-scale code gives all ones", y, 1023, 0);
  endtask

  task automatic t_window;
    @(negedge clk); in_valid = 1; in_t = '0;
    @(negedge clk); in_valid = 0;
    repeat (1023) @(negedge clk);
    check("R6 not done after 1023 edges", int'(out_valid), 0, 0);
    @(negedge clk);
    check("R6 done after 1024 edges", int'(out_valid), 1, 0);
    out_ready = 1; @(negedge clk); out_ready = 0;
  endtask

  task automatic t_backpressure;
    int y0;
    @(negedge clk); in_valid = 1; in_t = '0;
    @(negedge clk); in_valid = 0;
    while (!out_valid) @(negedge clk);
    y0 = int'(out_y);
    in_valid = 1; in_t = 10'd1023;
    repeat (20) @(negedge clk);
    check("R8 out_valid held", int'(out_valid), 1, 0);
    check("R8 out_y stable", int'(out_y), y0, 0);
    check("R8 in_ready low while pending", int'(in_ready), 0, 0);
    in_valid = 0;
    out_ready = 1; @(negedge clk); out_ready = 0;
    check("R8 released after out_ready", int'(out_valid), 0, 0);
    check("R8 idle again", int'(in_ready), 1, 0);
  endtask

  task automatic t_cfg_guard;
    int y;
    wr(0, 0);
    @(negedge clk); in_valid = 1; in_t = '0;
    @(negedge clk); in_valid = 0;
    repeat (10) @(negedge clk);
    cfg_we = 1; cfg_idx = '0; cfg_val = 10'd1023;
    @(negedge clk); cfg_we = 0;
    while (!out_valid) @(negedge clk);
    check("R9 write during run ignored", int'(out_y), 0, 0);
    out_ready = 1; @(negedge clk); out_ready = 0;
    run(0, y);
    check("R9 b0 still zero", y, 0, 0);
    wr(7, 1023); run(0, y);
    check("R9 out-of-range index ignored", y, 0, 0);
  endtask

  task automatic t_gamma;
    int c [DEG+1];
    int y;
    int ts [3] = '{100, 512, 900};
    bcoef = '{0.0955, 0.7207, 0.3476, 0.9988, 0.7017, 0.9695, 0.9939};
    for (int i = 0; i <= DEG; i++) c[i] = $rtoi(bcoef[i] * 1023.0 + 0.5);
    load(c);
    foreach (ts[k]) begin
      run(ts[k], y);
      check("R5 gamma evaluation", y, expect_y(c, ts[k]), 64);
    end
  endtask

  task automatic t_identity;
    int c [DEG+1];
    int y;
    for (int i = 0; i <= DEG; i++) c[i] = $rtoi(real'(i) * 1023.0 / real'(DEG) + 0.5);
    load(c);
    run(300, y);
    check("R10 identity t=300", y, expect_y(c, 300), 48);
    run(700, y);
    check("R10 identity t=700", y, expect_y(c, 700), 48);
    check("R10 identity near t", y, 700, 48);
  endtask

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_ends;
    t_window;
    t_backpressure;
    t_cfg_guard;
    t_gamma;
    t_identity;
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule